// File: doc/BRIEF.md
# Write-back invalidate snoop controller

This block keeps the coherence state of one line frame in a private write-back cache that sits on a shared, atomic snooping bus. The line is in one of three states: Invalid (holds nothing), Shared (a clean, read-only copy that matches memory) or Exclusive (the only copy, writable and dirty). Two kinds of event drive it. Local processor reads and writes arrive with a flag that says whether they target a different address that maps to the same frame. Snooped read misses and write misses from other caches arrive already matched to this line's address.

When a request cannot be served from the line as it stands, the controller asks for the bus and waits for a grant. Once it has the grant it issues a write-back if a dirty victim must be evicted, then issues a read miss or a write miss, and only then commits the new state. A snoop that hits the line while the controller is waiting is handled at once. The pending request is then evaluated again against the new state when the grant arrives. When a snoop finds the line dirty, the controller supplies the data by issuing a write-back and tells memory to abort its own reply.

Top module: `wb_snoop_ctrl`

## Requirements
- R1: After reset the line is Invalid and all outputs are low. State codes on `line_state` are Invalid=0, Shared=1, Exclusive=2. Command codes on `bus_cmd` are read miss=1, write miss=2, write-back=3, and the code is 0 whenever `bus_cmd_valid` is low.
- R2: A local read to an Invalid line raises `bus_req`. After the grant it issues one read-miss pulse and the line becomes Shared in that same cycle.
- R3: A local write to an Invalid or Shared line raises `bus_req`. After the grant it issues one write-miss pulse and the line becomes Exclusive in that same cycle.
- R4: A local read hit in Shared or Exclusive, or a write hit in Exclusive, pulses `cpu_done` one cycle after acceptance. It leaves the state unchanged and produces no `bus_req` and no bus command.
- R5: A snooped write miss moves Shared to Invalid with no bus command. In Exclusive it issues one write-back pulse together with `mem_abort` and moves to Invalid. In Invalid it has no effect.
- R6: A snooped read miss in Exclusive issues one write-back pulse together with `mem_abort` and moves to Shared. In Shared or Invalid it has no effect.
- R7: A local request to another address while the line is Exclusive issues, after the grant, a write-back (without `mem_abort`) in one cycle and then the miss in the next cycle. A read ends in Shared and a write ends in Exclusive. From Shared, such a request issues only the miss.
- R8: For a request that needs the bus, `bus_req` stays high from the cycle after acceptance until the cycle of the final miss. No command is issued and no state changes for that request until `bus_gnt` is seen. `cpu_done` pulses together with the final miss.
- R9: A snoop that arrives while the controller waits for a grant is handled first, as in R5 and R6. The pending request is then served at grant time from the updated state, so a victim that the snoop already cleaned is not written back again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | One-cycle local request strobe, accepted while idle |
| cpu_req_write | input | 1 | Request is a write (0 = read) |
| cpu_req_other | input | 1 | Request targets another address mapped to this frame |
| cpu_done | output | 1 | Pulse: local request completed |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership granted |
| bus_cmd_valid | output | 1 | Pulse: a bus command is issued this cycle |
| bus_cmd | output | 2 | Command code (1 read miss, 2 write miss, 3 write-back) |
| mem_abort | output | 1 | Pulse: memory must drop its reply, this cache supplies the data |
| snoop_valid | input | 1 | Snooped miss matching this line |
| snoop_write | input | 1 | Snooped miss is a write miss (0 = read miss) |
| line_state | output | 2 | Current coherence state of the line |

## Verification
A wrong internal state becomes visible at the ports within one clock. `line_state` shows it directly, and the next request or snoop then produces the wrong traffic: a missing or extra write-back, a missing `mem_abort`, or a bus request for what should have been a hit. The bench runs a behavioural model next to the design and compares every output on every cycle. A wrong state or a misplaced pulse is therefore reported in the cycle it first appears. Snoops injected during the grant wait check that the request is evaluated again at grant time and not acted on from a stale state.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LINE_INV = 2'd0,
        LINE_SHR = 2'd1,
        LINE_EXC = 2'd2
    } line_e;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_RDMISS = 2'd1,
        CMD_WRMISS = 2'd2,
        CMD_WRBACK = 2'd3
    } bcmd_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_FILL = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e ph;
        line_e  line;
        logic   pend_wr;
        logic   pend_oth;
        logic   bus_req;
        logic   cmd_vld;
        bcmd_e  cmd;
        logic   abort;
        logic   done;
    } ctl_s;

endpackage

// File: rtl/coh_cpu_eval.sv
module coh_cpu_eval
    import coh_pkg::*;
(
    input  line_e line,
    input  logic  wr,
    input  logic  oth,
    output logic  hit_ok,
    output logic  need_wb,
    output bcmd_e miss_cmd,
    output line_e fill_line
);
    always_comb begin
        hit_ok    = (line != LINE_INV) && !oth && (!wr || line == LINE_EXC);
        need_wb   = (line == LINE_EXC) && oth;
        miss_cmd  = wr ? CMD_WRMISS : CMD_RDMISS;
        fill_line = wr ? LINE_EXC : LINE_SHR;
    end
endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
    import coh_pkg::*;
(
    input  line_e line,
    input  logic  snp_wr,
    output logic  supply,
    output line_e nxt
);
    always_comb begin
        supply = 1'b0;
        nxt    = line;
        case (line)
            LINE_EXC: begin
                supply = 1'b1;
                nxt    = snp_wr ? LINE_INV : LINE_SHR;
            end
            LINE_SHR: begin
                if (snp_wr) nxt = LINE_INV;
            end
            default: nxt = line;
        endcase
    end
endmodule

// File: rtl/wb_snoop_ctrl.sv
module wb_snoop_ctrl
    import coh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req_valid,
    input  logic       cpu_req_write,
    input  logic       cpu_req_other,
    output logic       cpu_done,
    output logic       bus_req,
    input  logic       bus_gnt,
    output logic       bus_cmd_valid,
    output logic [1:0] bus_cmd,
    output logic       mem_abort,
    input  logic       snoop_valid,
    input  logic       snoop_write,
    output logic [1:0] line_state
);

    localparam ctl_s CTL_RST = '{
        ph: PH_IDLE, line: LINE_INV, pend_wr: 1'b0, pend_oth: 1'b0,
        bus_req: 1'b0, cmd_vld: 1'b0, cmd: CMD_NONE, abort: 1'b0, done: 1'b0
    };

    ctl_s  r_q, r_d;

    logic  ev_wr, ev_oth;
    logic  ev_hit, ev_wb;
    bcmd_e ev_cmd;
    line_e ev_fill;
    logic  sn_supply;
    line_e sn_next;

    // Request evaluation: live inputs while idle, latched request afterwards.
    assign ev_wr  = (r_q.ph == PH_IDLE) ? cpu_req_write : r_q.pend_wr;
    assign ev_oth = (r_q.ph == PH_IDLE) ? cpu_req_other : r_q.pend_oth;

    coh_cpu_eval u_eval (
        .line      (r_q.line),
        .wr        (ev_wr),
        .oth       (ev_oth),
        .hit_ok    (ev_hit),
        .need_wb   (ev_wb),
        .miss_cmd  (ev_cmd),
        .fill_line (ev_fill)
    );

    coh_snoop_resp u_snoop (
        .line   (r_q.line),
        .snp_wr (snoop_write),
        .supply (sn_supply),
        .nxt    (sn_next)
    );

    always_comb begin
        r_d         = r_q;
        r_d.cmd_vld = 1'b0;
        r_d.cmd     = CMD_NONE;
        r_d.abort   = 1'b0;
        r_d.done    = 1'b0;
        case (r_q.ph)
            PH_IDLE: begin
                r_d.bus_req = 1'b0;
                if (snoop_valid) begin
                    r_d.line    = sn_next;
                    r_d.cmd_vld = sn_supply;
                    r_d.cmd     = sn_supply ? CMD_WRBACK : CMD_NONE;
                    r_d.abort   = sn_supply;
                end else if (cpu_req_valid) begin
                    if (ev_hit) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.ph       = PH_WAIT;
                        r_d.bus_req  = 1'b1;
                        r_d.pend_wr  = cpu_req_write;
                        r_d.pend_oth = cpu_req_other;
                    end
                end
            end
            PH_WAIT: begin
                r_d.bus_req = 1'b1;
                if (snoop_valid) begin
                    // Snoop first; the request is re-evaluated at grant time.
                    r_d.line    = sn_next;
                    r_d.cmd_vld = sn_supply;
                    r_d.cmd     = sn_supply ? CMD_WRBACK : CMD_NONE;
                    r_d.abort   = sn_supply;
                end else if (bus_gnt) begin
                    r_d.cmd_vld = 1'b1;
                    if (ev_wb) begin
                        r_d.cmd = CMD_WRBACK;
                        r_d.ph  = PH_FILL;
                    end else begin
                        r_d.cmd     = ev_cmd;
                        r_d.line    = ev_fill;
                        r_d.done    = 1'b1;
                        r_d.ph      = PH_IDLE;
                        r_d.bus_req = 1'b0;
                    end
                end
            end
            PH_FILL: begin
                r_d.cmd_vld = 1'b1;
                r_d.cmd     = ev_cmd;
                r_d.line    = ev_fill;
                r_d.done    = 1'b1;
                r_d.ph      = PH_IDLE;
                r_d.bus_req = 1'b0;
            end
            default: r_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTL_RST;
        else        r_q <= r_d;
    end

    assign cpu_done      = r_q.done;
    assign bus_req       = r_q.bus_req;
    assign bus_cmd_valid = r_q.cmd_vld;
    assign bus_cmd       = r_q.cmd;
    assign mem_abort     = r_q.abort;
    assign line_state    = r_q.line;

    // R5 R6 R7: a write-back is only ever issued from a dirty line
    a_r7_wb_from_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_cmd == CMD_WRBACK) |-> $past(r_q.line) == LINE_EXC);

    // R6: memory abort only accompanies a write-back
    a_r6_abort_with_wb: assert property (@(posedge clk) disable iff (!rst_n)
        mem_abort |-> (bus_cmd_valid && bus_cmd == CMD_WRBACK));

    // R3: entering Exclusive requires a write miss completing a request
    a_r3_excl_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == LINE_EXC && $past(line_state) != LINE_EXC)
        |-> (bus_cmd_valid && bus_cmd == CMD_WRMISS && cpu_done));

    // R8: a miss command only follows a granted bus request
    a_r8_miss_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && (bus_cmd == CMD_RDMISS || bus_cmd == CMD_WRMISS))
        |-> ($past(bus_gnt) || $past(r_q.ph) == PH_FILL) && $past(bus_req));

    // R4: completion without a prior bus request carries no bus command
    a_r4_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && !$past(bus_req)) |-> !bus_cmd_valid);

endmodule

// File: tb/wb_snoop_ctrl_test.sv
`timescale 1ns/1ps
module wb_snoop_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req_valid = 1'b0, cpu_req_write = 1'b0, cpu_req_other = 1'b0;
    logic       bus_gnt = 1'b0, snoop_valid = 1'b0, snoop_write = 1'b0;
    logic       cpu_done, bus_req, bus_cmd_valid, mem_abort;
    logic [1:0] bus_cmd, line_state;

    always #2 clk = ~clk;

    wb_snoop_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_other(cpu_req_other), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .mem_abort(mem_abort),
        .snoop_valid(snoop_valid), .snoop_write(snoop_write),
        .line_state(line_state)
    );

    int    n_chk = 0, n_fail = 0;
    int    n_wb = 0, n_abort = 0;
    string cur_req = "R1";
    bit    finished = 0;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: line code, waiting flag, queue of follow-up commands
    int m_line = 0, m_busy = 0, m_wr = 0, m_oth = 0;
    int mq[$];
    int e_req = 0, e_vld = 0, e_cmd = 0, e_abort = 0, e_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_line = 0; m_busy = 0; m_wr = 0; m_oth = 0; mq.delete();
            e_req = 0; e_vld = 0; e_cmd = 0; e_abort = 0; e_done = 0;
        end else begin
            e_vld = 0; e_cmd = 0; e_abort = 0; e_done = 0;
            if (mq.size() > 0) begin
                e_vld = 1; e_cmd = mq.pop_front();
                m_line = m_wr ? 2 : 1; e_done = 1; m_busy = 0; e_req = 0;
            end else if (snoop_valid) begin
                if (m_line == 2) begin
                    e_vld = 1; e_cmd = 3; e_abort = 1;
                    m_line = snoop_write ? 0 : 1;
                end else if (m_line == 1 && snoop_write) begin
                    m_line = 0;
                end
            end else if (m_busy == 1 && bus_gnt) begin
                if (m_line == 2 && m_oth == 1) begin
                    e_vld = 1; e_cmd = 3; mq.push_back(m_wr ? 2 : 1);
                end else begin
                    e_vld = 1; e_cmd = m_wr ? 2 : 1; m_line = m_wr ? 2 : 1;
                    e_done = 1; m_busy = 0; e_req = 0;
                end
            end else if (m_busy == 0 && cpu_req_valid) begin
                if (m_line != 0 && !cpu_req_other && (!cpu_req_write || m_line == 2))
                    e_done = 1;
                else begin
                    m_busy = 1; e_req = 1;
                    m_wr = int'(cpu_req_write); m_oth = int'(cpu_req_other);
                end
            end
        end
    end

    // Cycle-by-cycle comparison, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, "line_state", int'(line_state), m_line);
            chk(cur_req, "bus_req", int'(bus_req), e_req);
            chk(cur_req, "bus_cmd_valid", int'(bus_cmd_valid), e_vld);
            chk(cur_req, "bus_cmd", int'(bus_cmd), e_cmd);
            chk(cur_req, "mem_abort", int'(mem_abort), e_abort);
            chk(cur_req, "cpu_done", int'(cpu_done), e_done);
            if (bus_cmd_valid && bus_cmd == 2'd3) n_wb++;
            if (mem_abort) n_abort++;
        end
    end

    // snoop_kind: 0 none, 1 read miss, 2 write miss, injected in the first wait cycle
    task automatic cpu_op(bit wr, bit oth, int gnt_delay, int snoop_kind);
        int waited = 0;
        bit sn_sent = 0;
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_write = wr; cpu_req_other = oth;
        @(negedge clk);
        cpu_req_valid = 0; cpu_req_write = 0; cpu_req_other = 0;
        while (!cpu_done) begin
            snoop_valid = 0; snoop_write = 0;
            if (bus_req && !bus_gnt) begin
                if (snoop_kind != 0 && !sn_sent) begin
                    snoop_valid = 1; snoop_write = (snoop_kind == 2); sn_sent = 1;
                end else begin
                    if (waited >= gnt_delay) bus_gnt = 1;
                    waited++;
                end
            end
            @(negedge clk);
        end
        snoop_valid = 0; snoop_write = 0; bus_gnt = 0;
    endtask

    task automatic snoop(bit wr);
        @(negedge clk);
        snoop_valid = 1; snoop_write = wr;
        @(negedge clk);
        snoop_valid = 0; snoop_write = 0;
    endtask

    initial begin
        int wb0, ab0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", "reset line_state", int'(line_state), 0);
        chk("R1", "reset bus_req", int'(bus_req), 0);
        chk("R1", "reset bus_cmd", int'(bus_cmd), 0);
        chk("R1", "reset cpu_done", int'(cpu_done), 0);

        cur_req = "R2"; cpu_op(0, 0, 2, 0);
        chk("R2", "read from Invalid", int'(line_state), 1);
        cur_req = "R4"; cpu_op(0, 0, 0, 0);
        chk("R4", "read hit Shared", int'(line_state), 1);
        cur_req = "R3"; cpu_op(1, 0, 0, 0);
        chk("R3", "write from Shared", int'(line_state), 2);
        cur_req = "R4"; cpu_op(1, 0, 0, 0); cpu_op(0, 0, 0, 0);
        chk("R4", "hits in Exclusive", int'(line_state), 2);

        cur_req = "R6"; ab0 = n_abort; snoop(0); @(negedge clk);
        chk("R6", "snoop read in Exclusive", int'(line_state), 1);
        chk("R6", "abort count", n_abort - ab0, 1);
        snoop(0); @(negedge clk);
        chk("R6", "snoop read in Shared", int'(line_state), 1);

        cur_req = "R5"; snoop(1); @(negedge clk);
        chk("R5", "snoop write in Shared", int'(line_state), 0);
        snoop(1); @(negedge clk);
        chk("R5", "snoop write in Invalid", int'(line_state), 0);
        cur_req = "R3"; cpu_op(1, 0, 1, 0);
        chk("R3", "write from Invalid", int'(line_state), 2);
        cur_req = "R5"; wb0 = n_wb; snoop(1); @(negedge clk);
        chk("R5", "snoop write in Exclusive", int'(line_state), 0);
        chk("R5", "write-back count", n_wb - wb0, 1);

        cur_req = "R7"; cpu_op(1, 0, 0, 0);
        wb0 = n_wb; ab0 = n_abort; cpu_op(0, 1, 1, 0);
        chk("R7", "replacement read", int'(line_state), 1);
        chk("R7", "replacement write-back", n_wb - wb0, 1);
        chk("R7", "no abort on replacement", n_abort - ab0, 0);
        cpu_op(1, 0, 0, 0); cpu_op(1, 1, 0, 0);
        chk("R7", "replacement write", int'(line_state), 2);
        cpu_op(0, 1, 0, 0); wb0 = n_wb; cpu_op(1, 1, 0, 0);
        chk("R7", "other-address write from Shared", int'(line_state), 2);
        chk("R7", "no write-back from Shared", n_wb - wb0, 0);

        cur_req = "R8"; cpu_op(0, 1, 6, 0);
        chk("R8", "long grant wait", int'(line_state), 1);

        cur_req = "R9"; cpu_op(1, 0, 0, 0);
        wb0 = n_wb; ab0 = n_abort; cpu_op(0, 1, 3, 2);
        chk("R9", "snoop write during wait", int'(line_state), 1);
        chk("R9", "single write-back", n_wb - wb0, 1);
        chk("R9", "abort from snoop", n_abort - ab0, 1);
        cpu_op(1, 0, 0, 0); wb0 = n_wb; cpu_op(1, 1, 2, 1);
        chk("R9", "snoop read during wait", int'(line_state), 2);
        chk("R9", "no second write-back", n_wb - wb0, 1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule